// File: doc/BRIEF.md
# Prioritized Result Return Arbiter

This block moves conversion results from three producers into a bank of result FIFOs through one shared write port. Two producers are on-chip converter channels and one is an external converter link. Each producer presents a result word, an optional time-stamp word, a destination FIFO index and a valid flag. The arbiter answers with a per-source ready pulse. When a single source has data and its FIFO has room, the word is written in that same cycle.

When several sources are valid together, a fixed priority decides: on-chip channel 0 first, then on-chip channel 1, then the external link. The priority is strict. If the highest-priority valid source cannot be served because its FIFO lacks room, no lower source is served either. A time-stamped result from an on-chip channel is written as a pair of words in consecutive cycles to the same FIFO: the result, then the stamp. No other source can slip between the two.

The controller has two states. `ST_ARB` chooses a source and writes its first word. A time-stamped grant takes the transition `ARB->STAMP` into `ST_STAMP`, where the stamp word is written and the source is released. From there the transition `STAMP->ARB` is always taken. A single-word grant, or no grant at all, keeps `ARB->ARB`. Reset forces `ST_ARB`.

Top module: `res_return_arb`

## Requirements
- R1: A lone valid source whose FIFO has room is written in the same cycle: `wr_en`=1, `wr_fifo`=its destination, `wr_data`=its result word.
- R2: Source 0 (bit 0 of `src_valid`) is granted ahead of sources 1 and 2 whenever it is valid in `ST_ARB`.
- R3: Source 1 is granted ahead of source 2 when source 0 is not valid.
- R4: Priority is strict. If the highest-priority valid source is blocked for lack of room, no write occurs and no lower source gets ready.
- R5: A time-stamped grant writes the result word and then, in the next cycle, the stamp word, with the same `wr_fifo` value in both cycles.
- R6: Between the two words of a pair no other source is granted. The owning source gets `src_ready` only with the second word, and gets no ready with the first.
- R7: A pair starts only when bit [dest] of `fifo_room2` is 1. A single word needs bit [dest] of `fifo_room1` set to 1 and ignores `fifo_room2`.
- R8: At most one `src_ready` bit is high in a cycle, and only in a cycle with `wr_en`=1.
- R9: Source 2 (external) always writes one word. Its `src_ts_en` bit has no effect, and its `src_stamp` word is never written.
- R10: While `rst` is 1, `wr_en` and all `src_ready` bits are 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 3 | Per-source result available (bit 0 highest priority) |
| src_ts_en | input | 3 | Per-source: a stamp word follows the result |
| src_word | input | 3x16 | Per-source result word |
| src_stamp | input | 3x16 | Per-source time-stamp word |
| src_dest | input | 3xIDX_W | Per-source destination FIFO index |
| fifo_room1 | input | NUM_FIFO | Per-FIFO: at least one free entry |
| fifo_room2 | input | NUM_FIFO | Per-FIFO: at least two free entries |
| src_ready | output | 3 | Per-source: word taken and source released this cycle |
| wr_en | output | 1 | FIFO write strobe |
| wr_fifo | output | IDX_W | FIFO index of the write |
| wr_data | output | 16 | Word written |

## Verification
Two functions can fall in the same cycle: the stamp half of a pair and a new request from a higher-priority source. The bench provokes this by raising source 0's valid flag during the second word of a source-1 pair. It then checks that the stamp word of source 1 is still the word written, and that only source 1 is released. A second collision happens when a blocked time-stamped source 0 and a ready-to-go source 1 meet in one cycle. That cycle is judged by the absence of any write or ready.

// File: rtl/rra_pkg.sv
package rra_pkg;
    localparam int NSRC    = 3;
    localparam int SRC_EXT = 2;
    localparam int SRC_W   = $clog2(NSRC);

    typedef enum logic {
        ST_ARB   = 1'b0,
        ST_STAMP = 1'b1
    } rra_state_e;
endpackage

// File: rtl/rra_prio_pick.sv
module rra_prio_pick #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt[i]       = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end

    assign any = blocked[N];

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rra_room_check.sv
module rra_room_check #(
    parameter int NUM_FIFO = 4,
    localparam int IDX_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
    input  logic [IDX_W-1:0]    dest,
    input  logic                pair,
    input  logic [NUM_FIFO-1:0] room1,
    input  logic [NUM_FIFO-1:0] room2,
    output logic                ok
);
    always_comb begin
        if (pair) ok = room2[dest];
        else      ok = room1[dest];
    end
endmodule

// File: rtl/res_return_arb.sv
module res_return_arb
    import rra_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_FIFO = 4,
    localparam int IDX_W   = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NSRC-1:0]              src_valid,
    input  logic [NSRC-1:0]              src_ts_en,
    input  logic [NSRC-1:0][DATA_W-1:0]  src_word,
    input  logic [NSRC-1:0][DATA_W-1:0]  src_stamp,
    input  logic [NSRC-1:0][IDX_W-1:0]   src_dest,
    input  logic [NUM_FIFO-1:0]          fifo_room1,
    input  logic [NUM_FIFO-1:0]          fifo_room2,
    output logic [NSRC-1:0]              src_ready,
    output logic                         wr_en,
    output logic [IDX_W-1:0]             wr_fifo,
    output logic [DATA_W-1:0]            wr_data
);
    rra_state_e       state_q, state_d;
    logic [SRC_W-1:0] owner_q, owner_d;

    logic [NSRC-1:0]  ts_cap;
    logic [NSRC-1:0]  pick_gnt;
    logic [SRC_W-1:0] pick_idx;
    logic             pick_any;
    logic             pick_pair;
    logic             room_ok;

    // Only on-chip channels may carry a stamp word.
    for (genvar s = 0; s < NSRC; s++) begin : g_ts_cap
        if (s == SRC_EXT) begin : g_ext
            assign ts_cap[s] = 1'b0;
        end else begin : g_onchip
            assign ts_cap[s] = src_ts_en[s];
        end
    end

    rra_prio_pick #(.N(NSRC)) u_pick (
        .req (src_valid),
        .gnt (pick_gnt),
        .idx (pick_idx),
        .any (pick_any)
    );

    assign pick_pair = |(pick_gnt & ts_cap);

    rra_room_check #(.NUM_FIFO(NUM_FIFO)) u_room (
        .dest  (src_dest[pick_idx]),
        .pair  (pick_pair),
        .room1 (fifo_room1),
        .room2 (fifo_room2),
        .ok    (room_ok)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARB;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // Outputs and transitions
    always_comb begin
        state_d   = state_q;
        owner_d   = owner_q;
        wr_en     = 1'b0;
        wr_fifo   = '0;
        wr_data   = '0;
        src_ready = '0;
        unique case (state_q)
            ST_ARB: begin
                if (!rst && pick_any && room_ok) begin
                    wr_en   = 1'b1;
                    wr_fifo = src_dest[pick_idx];
                    wr_data = src_word[pick_idx];
                    if (pick_pair) begin
                        state_d = ST_STAMP;     // ARB->STAMP
                        owner_d = pick_idx;
                    end else begin
                        src_ready = pick_gnt;   // ARB->ARB
                    end
                end
            end
            ST_STAMP: begin
                state_d = ST_ARB;               // STAMP->ARB
                if (!rst) begin
                    wr_en              = 1'b1;
                    wr_fifo            = src_dest[owner_q];
                    wr_data            = src_stamp[owner_q];
                    src_ready[owner_q] = 1'b1;
                end
            end
            default: state_d = ST_ARB;
        endcase
    end
endmodule

// File: rtl/rra_checker.sv
module rra_checker #(
    parameter int DATA_W   = 16,
    parameter int NUM_FIFO = 4,
    parameter int IDX_W    = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic [2:0]             src_valid,
    input logic [2:0][DATA_W-1:0] src_word,
    input logic [2:0][IDX_W-1:0]  src_dest,
    input logic [NUM_FIFO-1:0]    fifo_room1,
    input logic [NUM_FIFO-1:0]    fifo_room2,
    input logic [2:0]             src_ready,
    input logic                   wr_en,
    input logic [IDX_W-1:0]       wr_fifo,
    input logic [DATA_W-1:0]      wr_data
);
    logic mid_pair;   // current cycle is the stamp half of a pair

    always_ff @(posedge clk) begin
        if (rst) mid_pair <= 1'b0;
        else     mid_pair <= wr_en && (src_ready == 3'b000);
    end

    assert_src0_first_R2: assert property (@(posedge clk) disable iff (rst)
        (!mid_pair && wr_en && src_valid[0]) |-> (wr_data == src_word[0] && wr_fifo == src_dest[0]));

    assert_src1_over_ext_R3: assert property (@(posedge clk) disable iff (rst)
        (!mid_pair && wr_en && !src_valid[0] && src_valid[1]) |-> (wr_data == src_word[1]));

    assert_strict_order_R4: assert property (@(posedge clk) disable iff (rst)
        (!mid_pair && src_valid[0]) |-> (!src_ready[1] && !src_ready[2]));

    assert_pair_same_fifo_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && src_ready == 3'b000) |=> (wr_en && wr_fifo == $past(wr_fifo)));

    assert_pair_release_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && src_ready == 3'b000) |=> ($countones(src_ready) == 1));

    assert_room_single_R7: assert property (@(posedge clk) disable iff (rst)
        (!mid_pair && wr_en) |-> fifo_room1[wr_fifo] || fifo_room2[wr_fifo]);

    assert_room_pair_R7: assert property (@(posedge clk) disable iff (rst)
        (!mid_pair && wr_en && src_ready == 3'b000) |-> fifo_room2[wr_fifo]);

    assert_ready_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_ready));

    assert_ready_with_write_R8: assert property (@(posedge clk) disable iff (rst)
        (|src_ready) |-> wr_en);

    assert_ext_single_R9: assert property (@(posedge clk) disable iff (rst)
        (!mid_pair && wr_en && !src_valid[0] && !src_valid[1]) |-> src_ready[2]);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |-> (!wr_en && src_ready == 3'b000));
endmodule

bind res_return_arb rra_checker #(
    .DATA_W(DATA_W), .NUM_FIFO(NUM_FIFO), .IDX_W(IDX_W)
) chk_i (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_word(src_word),
    .src_dest(src_dest), .fifo_room1(fifo_room1), .fifo_room2(fifo_room2),
    .src_ready(src_ready), .wr_en(wr_en), .wr_fifo(wr_fifo), .wr_data(wr_data)
);

// File: tb/res_return_arb_tb_top.sv
module res_return_arb_tb_top;
    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       src_valid = '0;
    logic [2:0]       src_ts_en = '0;
    logic [2:0][15:0] src_word  = '0;
    logic [2:0][15:0] src_stamp = '0;
    logic [2:0][1:0]  src_dest  = '0;
    logic [3:0]       fifo_room1 = '0;
    logic [3:0]       fifo_room2 = '0;
    logic [2:0]       src_ready;
    logic             wr_en;
    logic [1:0]       wr_fifo;
    logic [15:0]      wr_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    res_return_arb dut_i (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_ts_en(src_ts_en),
        .src_word(src_word), .src_stamp(src_stamp), .src_dest(src_dest),
        .fifo_room1(fifo_room1), .fifo_room2(fifo_room2),
        .src_ready(src_ready), .wr_en(wr_en), .wr_fifo(wr_fifo), .wr_data(wr_data)
    );

    // {valid[2:0], ts_en[2:0], room1[3:0], room2[3:0], exp_wr, exp_src[1:0], exp_stamp, exp_ready[2:0]}
    localparam int NROW = 13;
    localparam logic [20:0] VEC [NROW] = '{
        21'b000_000_1111_1111_0_11_0_000,  // idle, nothing written
        21'b100_000_1111_1111_1_10_0_100,  // R1 lone external source
        21'b111_000_1111_1111_1_00_0_001,  // R2 source 0 wins
        21'b110_000_1111_1111_1_01_0_010,  // R3 source 1 over external
        21'b011_001_1111_1111_1_00_0_000,  // R5 pair start, no ready (R6)
        21'b011_001_1111_1111_1_00_1_001,  // R5 stamp word, release
        21'b010_010_1111_1111_1_01_0_000,  // R5 source 1 pair start
        21'b011_010_1111_1111_1_01_1_010,  // R6 source 0 cannot cut in
        21'b011_001_1111_1101_0_11_0_000,  // R4 R7 blocked pair stalls source 1
        21'b100_000_1111_0000_1_10_0_100,  // R7 single word ignores room2
        21'b100_000_0111_1111_0_11_0_000,  // R7 no room1, no write
        21'b100_100_1111_1111_1_10_0_100,  // R9 external stamp flag ignored
        21'b000_000_1111_1111_0_11_0_000   // R9 no second word follows
    };

    task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_sources(input int tag);
        for (int s = 0; s < 3; s++) begin
            src_word[s]  = 16'hA000 | 16'(s << 8) | 16'(tag);
            src_stamp[s] = 16'hC000 | 16'(s << 8) | 16'(tag);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        src_dest = {2'd3, 2'd2, 2'd1};
        set_sources(0);
        // R10: requests during reset must not produce a write
        src_valid  = 3'b111;
        fifo_room1 = 4'hF;
        fifo_room2 = 4'hF;
        repeat (2) @(negedge clk);
        #2;
        check("R10", {wr_en, wr_fifo, wr_data, src_ready}, 22'd0);
        @(negedge clk);
        src_valid = '0;
        rst = 1'b0;

        for (int r = 0; r < NROW; r++) begin
            logic [20:0] v;
            logic [21:0] exp;
            logic [21:0] act;
            logic [1:0]  es;
            @(negedge clk);
            v = VEC[r];
            set_sources(r + 1);
            src_valid  = v[20:18];
            src_ts_en  = v[17:15];
            fifo_room1 = v[14:11];
            fifo_room2 = v[10:7];
            #2;
            es = v[5:4];
            if (v[6]) begin
                exp = {1'b1, src_dest[es],
                       v[3] ? src_stamp[es] : src_word[es], v[2:0]};
                act = {wr_en, wr_fifo, wr_data, src_ready};
            end else begin
                exp = {1'b0, 2'b00, 16'h0000, v[2:0]};
                act = {wr_en, 2'b00, 16'h0000, src_ready};
            end
            check($sformatf("table row %0d", r), act, exp);
        end

        // R5 R6 directed: pair to FIFO 0 from source 1, stamp follows in next cycle
        @(negedge clk);
        src_dest   = {2'd3, 2'd0, 2'd1};
        set_sources(40);
        src_valid  = 3'b010;
        src_ts_en  = 3'b010;
        fifo_room1 = 4'hF;
        fifo_room2 = 4'b0001;
        #2;
        check("R5 first word", {wr_en, wr_fifo, wr_data, src_ready},
              {1'b1, 2'd0, src_word[1], 3'b000});
        @(negedge clk);
        src_valid = 3'b111;
        #2;
        check("R6 stamp word", {wr_en, wr_fifo, wr_data, src_ready},
              {1'b1, 2'd0, src_stamp[1], 3'b010});
        @(negedge clk);
        src_valid = 3'b001;
        src_ts_en = 3'b000;
        #2;
        check("R2 after pair", {wr_en, wr_fifo, wr_data, src_ready},
              {1'b1, 2'd1, src_word[0], 3'b001});

        // R10: reset in the middle of a pair drops the stamp half
        @(negedge clk);
        src_valid = 3'b001;
        src_ts_en = 3'b001;
        fifo_room2 = 4'hF;
        #2;
        check("R5 pair start", {wr_en, src_ready}, {1'b1, 3'b000});
        @(negedge clk);
        rst = 1'b1;
        #2;
        check("R10 mid pair", {wr_en, wr_fifo, wr_data, src_ready}, 22'd0);
        @(negedge clk);
        rst = 1'b0;
        src_valid = '0;
        #2;
        check("R10 after reset", {wr_en, src_ready}, 4'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule